// File: doc/BRIEF.md
# Three-Voice State-Variable Filter and Mixer

This block takes three signed voice samples on every clock and sends each one either into a second-order state-variable filter or around it. The filter advances by one integration step per clock. It is built from integers only, with fixed shifts, so its response is reproducible bit for bit. The selected highpass, bandpass and lowpass taps are added together and to the bypass sum and a fixed DC offset. The result is then scaled by a 4-bit volume.

Software programs the block through four byte-wide registers. Two of them form an 11-bit cutoff code. That code is driven out so that logic outside the block can turn it into the integrator coefficient, which comes back on `w0_in`. Before use, that coefficient is clamped to a ceiling that is also an input. The resonance field selects a reciprocal-Q factor from a built-in table of sixteen entries.

Top module: `svf_mixer`

## Requirements
- R1: A write with `wr_sel`=0 loads cutoff bits 2:0 from `wr_data[2:0]`. A write with `wr_sel`=1 loads cutoff bits 10:3 from `wr_data[7:0]`. The cutoff code is visible on `cutoff_o` from the cycle after the write.
- R2: A write with `wr_sel`=2 loads resonance from `wr_data[7:4]` and routing from `wr_data[3:0]`. A write with `wr_sel`=3 loads the voice-3 mute from bit 7, the highpass enable from bit 6, the bandpass enable from bit 5, the lowpass enable from bit 4 and volume from bits 3:0. A write takes effect on the clock edge that follows it.
- R3: Each voice is arithmetically shifted right by 7. Routing bits 0, 1 and 2 send voices 1, 2 and 3 into the filter input; an unrouted voice goes to the bypass sum. Routing bit 3 changes nothing.
- R4: The voice-3 mute zeroes voice 3 only while routing bit 2 is clear. A routed voice 3 still reaches the filter.
- R5: On each edge, with `k` equal to the clamped coefficient shifted right by 6:
  - bp' = bp − (k·hp)>>14
  - lp' = lp − (k·bp)>>14, using the old bp
  - hp' = ((bp'·iq)>>10) − lp' − vi

  The bypass sum is registered on the same edge. With `k`=0, bp and lp hold their values.
- R6: `iq` is 1024/(0.707 + res/15), rounded to the nearest integer, for res 0 to 15.
- R7: The coefficient used is the smaller of `w0_in` and `w0_limit`.
- R8: `audio_o` = (bypass + the sum of the enabled taps, with no weighting − 454) × volume, truncated to 32 bits. It follows the registered state and the mode register without a further register. Volume 0 gives 0.
- R9: Reset clears all registers and filter state, so `audio_o` and `cutoff_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 cutoff low, 1 cutoff high, 2 resonance/routing, 3 mode/volume |
| wr_data | input | 8 | Write byte |
| voice1 | input | 20 | Voice 1 sample, signed |
| voice2 | input | 20 | Voice 2 sample, signed |
| voice3 | input | 20 | Voice 3 sample, signed |
| w0_in | input | 17 | Integrator coefficient derived from the cutoff code |
| w0_limit | input | 17 | Ceiling applied to `w0_in` |
| cutoff_o | output | 11 | Stored cutoff code |
| audio_o | output | 32 | Mixed, volume-scaled output, signed |

## Verification
A register write and an integration step share the same clock edge. The integration step on that edge must still use the routing, resonance and mute values that held before the write. The bench provokes this by changing the routing byte on the same edge where voice 1 swings from one polarity to the other, with the filter running. A bit-level model advances alongside the block and applies the write only after computing that edge, so a design that lets the new routing leak into the edge shows up as an output mismatch on the following samples.

// File: rtl/svf_mixer.sv
module svf_mixer #(
  parameter int VW        = 20,
  parameter int W0W       = 17,
  parameter int SW        = 32,
  parameter int VSH       = 7,
  parameter int DC_OFFSET = -454
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [7:0]           wr_data,
  input  logic signed [VW-1:0] voice1,
  input  logic signed [VW-1:0] voice2,
  input  logic signed [VW-1:0] voice3,
  input  logic [W0W-1:0]       w0_in,
  input  logic [W0W-1:0]       w0_limit,
  output logic [10:0]          cutoff_o,
  output logic signed [SW-1:0] audio_o
);
  localparam int K_SH  = 6;
  localparam int BP_SH = 14;
  localparam int Q_SH  = 10;
  localparam int PW    = 2 * SW;
  localparam logic signed [SW-1:0] DC_S = SW'(DC_OFFSET);

  logic [10:0] cut_q;
  logic [3:0]  res_q;
  logic [2:0]  route_q;
  logic        mute3_q, hp_en, bp_en, lp_en;
  logic [3:0]  vol_q;

  logic signed [SW-1:0] vhp, vbp, vlp, vnf;

  logic signed [SW-1:0] x1, x2, x3, s1, s2, s3, s3m, vi, vnf_n;
  assign x1 = voice1;
  assign x2 = voice2;
  assign x3 = voice3;
  assign s1 = x1 >>> VSH;
  assign s2 = x2 >>> VSH;
  assign s3 = x3 >>> VSH;
  assign s3m = (mute3_q && !route_q[2]) ? '0 : s3;

  assign vi    = (route_q[0] ? s1 : '0) + (route_q[1] ? s2 : '0) + (route_q[2] ? s3m : '0);
  assign vnf_n = (route_q[0] ? '0 : s1) + (route_q[1] ? '0 : s2) + (route_q[2] ? '0 : s3m);

  logic [W0W-1:0] w0_eff, kcoef;
  assign w0_eff = (w0_in > w0_limit) ? w0_limit : w0_in;
  assign kcoef  = w0_eff >> K_SH;

  logic [11:0] invq;
  always_comb begin
    case (res_q)
      4'd0:    invq = 12'd1448;
      4'd1:    invq = 12'd1324;
      4'd2:    invq = 12'd1219;
      4'd3:    invq = 12'd1129;
      4'd4:    invq = 12'd1052;
      4'd5:    invq = 12'd984;
      4'd6:    invq = 12'd925;
      4'd7:    invq = 12'd872;
      4'd8:    invq = 12'd826;
      4'd9:    invq = 12'd783;
      4'd10:   invq = 12'd745;
      4'd11:   invq = 12'd711;
      4'd12:   invq = 12'd679;
      4'd13:   invq = 12'd651;
      4'd14:   invq = 12'd624;
      default: invq = 12'd600;
    endcase
  end

  logic signed [PW-1:0] k_w, hp_w, bp_w, nbp_w, q_w;
  logic signed [SW-1:0] nbp, nlp, nhp;
  assign k_w   = {{(PW-W0W){1'b0}}, kcoef};
  assign q_w   = {{(PW-12){1'b0}}, invq};
  assign hp_w  = vhp;
  assign bp_w  = vbp;
  assign nbp   = vbp - SW'((k_w * hp_w) >>> BP_SH);
  assign nlp   = vlp - SW'((k_w * bp_w) >>> BP_SH);
  assign nbp_w = nbp;
  assign nhp   = SW'((nbp_w * q_w) >>> Q_SH) - nlp - vi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cut_q   <= '0;
      res_q   <= '0;
      route_q <= '0;
      mute3_q <= 1'b0;
      hp_en   <= 1'b0;
      bp_en   <= 1'b0;
      lp_en   <= 1'b0;
      vol_q   <= '0;
      vhp     <= '0;
      vbp     <= '0;
      vlp     <= '0;
      vnf     <= '0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          2'd0: cut_q[2:0]  <= wr_data[2:0];
          2'd1: cut_q[10:3] <= wr_data;
          2'd2: begin
            res_q   <= wr_data[7:4];
            route_q <= wr_data[2:0];
          end
          default: begin
            mute3_q <= wr_data[7];
            hp_en   <= wr_data[6];
            bp_en   <= wr_data[5];
            lp_en   <= wr_data[4];
            vol_q   <= wr_data[3:0];
          end
        endcase
      end
      vbp <= nbp;
      vlp <= nlp;
      vhp <= nhp;
      vnf <= vnf_n;
    end
  end

  logic signed [SW-1:0] tap_sum, mix, vol_s;
  assign tap_sum  = (hp_en ? vhp : '0) + (bp_en ? vbp : '0) + (lp_en ? vlp : '0);
  assign mix      = vnf + tap_sum + DC_S;
  assign vol_s    = {{(SW-4){1'b0}}, vol_q};
  assign audio_o  = mix * vol_s;
  assign cutoff_o = cut_q;

  p_cut_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> cutoff_o[2:0] == $past(wr_data[2:0]));
  p_cut_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1) |=> cutoff_o[10:3] == $past(wr_data));
  p_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2) |=> route_q == $past(wr_data[2:0]));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kcoef == '0) |=> ($stable(vbp) && $stable(vlp)));
  p_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kcoef <= (w0_limit >> K_SH));
  p_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vol_q == 4'd0) |-> (audio_o == '0));
endmodule

// File: tb/svf_mixer_bench.sv
module svf_mixer_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic signed [19:0] v1 = '0, v2 = '0, v3 = '0;
  logic [16:0] w0_in = '0, w0_limit = '1;
  logic [10:0] cutoff_o;
  logic signed [31:0] audio_o;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  svf_mixer u_svf_mixer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .voice1(v1), .voice2(v2), .voice3(v3), .w0_in(w0_in), .w0_limit(w0_limit),
    .cutoff_o(cutoff_o), .audio_o(audio_o)
  );

  typedef struct packed {
    logic signed [19:0] a, b, c;
    logic [7:0] rr, mv;
    logic signed [31:0] exp;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{20'sd1280, 20'sd2560, 20'sd5120, 8'h00, 8'h01, -32'sd384},
    '{20'sd1280, 20'sd2560, 20'sd5120, 8'h01, 8'h41, -32'sd404},
    '{20'sd1280, 20'sd2560, 20'sd5120, 8'h07, 8'h4F, -32'sd7860},
    '{20'sd1280, 20'sd2560, 20'sd5120, 8'h08, 8'h02, -32'sd768},
    '{20'sd1280, 20'sd2560, 20'sd5120, 8'h00, 8'h81, -32'sd424},
    '{20'sd1280, 20'sd2560, 20'sd5120, 8'h04, 8'hC1, -32'sd464},
    '{20'sd1280, 20'sd2560, 20'sd5120, 8'h03, 8'h31, -32'sd414},
    '{20'sd1280, 20'sd2560, 20'sd5120, 8'h00, 8'h70, 32'sd0},
    '{-20'sd1, -20'sd640, 20'sd0, 8'h02, 8'h41, -32'sd450}
  };

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  longint mhp, mbp, mlp, mnf;
  logic [3:0] m_res, m_vol;
  logic [2:0] m_route;
  logic m_mute, m_hp, m_bp, m_lp;

  function automatic longint iq(input int r);
    return longint'($rtoi(1024.0 / (0.707 + r / 15.0) + 0.5));
  endfunction

  task automatic mreset();
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    mhp = 0; mbp = 0; mlp = 0; mnf = 0;
    m_res = 0; m_vol = 0; m_route = 0;
    m_mute = 0; m_hp = 0; m_bp = 0; m_lp = 0;
  endtask

  task automatic mstep(input string tag);
    longint s1, s2, s3, vi, vnf, w, k, nbp, nlp, nhp, e;
    logic we; logic [1:0] ws; logic [7:0] wd;
    s1 = longint'(v1) >>> 7;
    s2 = longint'(v2) >>> 7;
    s3 = longint'(v3) >>> 7;
    if (m_mute && !m_route[2]) s3 = 0;
    vi  = (m_route[0] ? s1 : 0) + (m_route[1] ? s2 : 0) + (m_route[2] ? s3 : 0);
    vnf = (m_route[0] ? 0 : s1) + (m_route[1] ? 0 : s2) + (m_route[2] ? 0 : s3);
    w = (w0_in > w0_limit) ? longint'(w0_limit) : longint'(w0_in);
    k = w >> 6;
    nbp = mbp - ((k * mhp) >>> 14);
    nlp = mlp - ((k * mbp) >>> 14);
    nhp = ((nbp * iq(int'(m_res))) >>> 10) - nlp - vi;
    we = wr_en; ws = wr_sel; wd = wr_data;
    step();
    mbp = nbp; mlp = nlp; mhp = nhp; mnf = vnf;
    if (we && ws == 2'd2) begin m_res = wd[7:4]; m_route = wd[2:0]; end
    if (we && ws == 2'd3) begin
      m_mute = wd[7]; m_hp = wd[6]; m_bp = wd[5]; m_lp = wd[4]; m_vol = wd[3:0];
    end
    e = (mnf + (m_hp ? mhp : 0) + (m_bp ? mbp : 0) + (m_lp ? mlp : 0) - 454) * longint'(m_vol);
    chk(tag, longint'(audio_o), longint'(int'(e)));
  endtask

  task automatic mwr(input logic [1:0] s, input logic [7:0] d, input string tag);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    mstep(tag);
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step();
    chk("R9 audio after reset", longint'(audio_o), 0);
    chk("R9 cutoff after reset", longint'(cutoff_o), 0);
    rst_n = 1'b1;
    step();

    wr(2'd0, 8'hFF);
    chk("R1 cutoff low", longint'(cutoff_o), 11'h007);
    wr(2'd1, 8'hA5);
    chk("R1 cutoff high", longint'(cutoff_o), 11'h52F);
    wr(2'd0, 8'h00);
    chk("R1 cutoff low cleared", longint'(cutoff_o), 11'h528);

    w0_in = '0;
    for (int i = 0; i < 9; i++) begin
      v1 = VEC[i].a; v2 = VEC[i].b; v3 = VEC[i].c;
      wr(2'd2, VEC[i].rr);
      wr(2'd3, VEC[i].mv);
      step();
      step();
      chk($sformatf("R2 R3 R4 R8 vector %0d", i), longint'(audio_o), longint'(VEC[i].exp));
    end

    mreset();
    w0_limit = '1;
    w0_in = 17'd30000;
    v2 = 20'sd1280; v3 = -20'sd2560;
    mwr(2'd3, 8'h7F, "R8 mode write");
    for (int r = 0; r < 16; r++) begin
      mwr(2'd2, {r[3:0], 4'h3}, "R6 resonance write");
      for (int k = 0; k < 20; k++) begin
        v1 = (((k / 5) % 2) != 0) ? 20'sd200000 : -20'sd200000;
        mstep($sformatf("R5 R6 res %0d", r));
      end
    end

    mwr(2'd2, 8'hF1, "R3 route write");
    mwr(2'd3, 8'hA3, "R4 mute write");
    for (int k = 0; k < 60; k++) begin
      v3 = (((k / 7) % 2) != 0) ? 20'sd150000 : -20'sd90000;
      mstep("R4 muted bypass voice");
    end

    w0_in = 17'd100000;
    w0_limit = 17'd20000;
    mwr(2'd3, 8'h7C, "R8 mode write");
    for (int k = 0; k < 80; k++) begin
      v1 = (((k / 9) % 2) != 0) ? 20'sd180000 : -20'sd180000;
      mstep("R7 clamped coefficient");
    end

    v1 = 20'sd220000;
    mwr(2'd2, 8'h57, "R5 write during step");
    v1 = -20'sd220000;
    for (int k = 0; k < 30; k++) mstep("R5 after concurrent write");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule